// File: doc/BRIEF.md
# Power-Managed Mode Controller

This block holds the power state of a small processor core. The core signals a sleep request with a one-cycle strobe. At that edge the controller samples an idle-enable bit and a two-bit source select and moves into the mode they encode. There are three kinds of mode. In a Run mode the CPU clock runs from the chosen source. In an Idle mode the CPU clock is stopped and the peripheral clock keeps running. In full Sleep both clocks are stopped. The controller drives the two clock gates and sends one-cycle requests to a separate clock switcher. The switcher reports back through a busy input.

Wake events, time-outs from an external watchdog counter and a primary-oscillator-ready input bring the core back out of low power. A wake from an Idle mode resumes in the Run mode that uses the same source. It stays there until the primary oscillator reports ready and then moves to the primary without further action from the core. A watchdog time-out acts as a wake while the CPU is stopped. While the CPU runs, a time-out instead produces a reset pulse.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is PRI_RUN (3'b000), both clock enables are high, and sw_req and wdt_reset are low.
- R2: A strobe seen in a Run mode with idle_en=0 enters the Run mode of the selected source, and with idle_en=1 the Idle mode of that source. src_sel 2'b00 selects primary, 2'b01 secondary, and 2'b10 or 2'b11 the RC source. Mode codes are PRI_RUN 000, SEC_RUN 001, RC_RUN 010, PRI_IDLE 100, SEC_IDLE 101, RC_IDLE 110 and SLEEP 111. The new mode is visible after the edge that samples the strobe.
- R3: A strobe with idle_en=0 and src_sel=2'b00 enters SLEEP, with cpu_clk_en and periph_clk_en both low.
- R4: When the source of the new mode differs from the current source, sw_req is high for exactly one cycle after the sampling edge, and sw_target carries the new source. SLEEP counts as primary. When the source is unchanged, no request is made.
- R5: cpu_clk_en is high only in Run modes, and periph_clk_en is low only in SLEEP.
- R6: Each strobe in a Run mode samples idle_en and src_sel again. A strobe that arrives while in an Idle mode or SLEEP has no effect.
- R7: A wake_evt in an Idle mode enters the Run mode of the same source one edge later. A wake_evt in SLEEP enters PRI_RUN.
- R8: After a wake onto a non-primary source, the mode stays in that Run mode while pri_ready is low. At the first edge where pri_ready is high and sw_busy is low, the mode becomes PRI_RUN and a request with sw_target=2'b00 is issued.
- R9: A wdt_timeout in an Idle mode or SLEEP wakes the controller as in R7 and raises no reset. In a Run mode it raises wdt_reset for one cycle and leaves the mode unchanged.
- R10: A wake that arrives while sw_busy is high is held. It takes effect at the first edge where sw_busy is low.
- R11: A wake_evt that arrives in a Run mode is not remembered. A later entry into an Idle mode is not ended by it.
- R12: The mode reached after a wake does not depend on idle_en or src_sel at the time of the wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_strobe | input | 1 | One-cycle sleep request from the core |
| idle_en | input | 1 | Idle-enable bit sampled on the strobe |
| src_sel | input | 2 | Clock source select sampled on the strobe |
| wake_evt | input | 1 | Wake event (interrupt or similar) |
| wdt_timeout | input | 1 | Time-out pulse from the watchdog counter |
| pri_ready | input | 1 | Primary oscillator is stable |
| sw_busy | input | 1 | Clock switcher is mid-switch |
| mode | output | 3 | Active mode code |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| sw_req | output | 1 | One-cycle clock switch request |
| sw_target | output | 2 | Source requested from the switcher |
| wdt_reset | output | 1 | Watchdog reset pulse |

## Verification
Every fault in the state register shows on the mode port and on the clock enables at the next edge. For that reason each scenario samples mode one cycle after its stimulus. A current-source register that holds the wrong value shows up as a missing or extra sw_req at the next strobe, or as the wrong Run mode after a wake. A broken wake latch only becomes visible some cycles later. It shows when sw_busy falls, or at the next Idle entry after a wake given in a Run mode, so the bench checks both of those moments.

// File: rtl/pm_pkg.sv
package pm_pkg;

    localparam int SRC_W  = 2;
    localparam int MODE_W = SRC_W + 1;

    typedef enum logic [SRC_W-1:0] {
        SRC_PRI = 2'b00,
        SRC_SEC = 2'b01,
        SRC_RC  = 2'b10
    } src_e;

    typedef enum logic [MODE_W-1:0] {
        M_PRI_RUN  = 3'b000,
        M_SEC_RUN  = 3'b001,
        M_RC_RUN   = 3'b010,
        M_PRI_IDLE = 3'b100,
        M_SEC_IDLE = 3'b101,
        M_RC_IDLE  = 3'b110,
        M_SLEEP    = 3'b111
    } mode_e;

    typedef struct packed {
        mode_e mode;
        src_e  src;
    } pm_target_t;

    function automatic src_e sel_to_src(input logic [SRC_W-1:0] sel);
        case (sel)
            2'b00:   return SRC_PRI;
            2'b01:   return SRC_SEC;
            default: return SRC_RC;
        endcase
    endfunction

    function automatic mode_e run_of(input src_e s);
        return mode_e'({1'b0, s});
    endfunction

    function automatic mode_e idle_of(input src_e s);
        return mode_e'({1'b1, s});
    endfunction

    function automatic logic cpu_runs(input mode_e m);
        return ~m[MODE_W-1];
    endfunction

endpackage

// File: rtl/pm_mode_decode.sv
module pm_mode_decode
    import pm_pkg::*;
(
    input  logic              idle_en,
    input  logic [SRC_W-1:0]  src_sel,
    output pm_target_t        target
);
    src_e sel_src;

    always_comb begin
        sel_src = sel_to_src(src_sel);
        if (!idle_en && sel_src == SRC_PRI) begin
            target.mode = M_SLEEP;
        end else if (idle_en) begin
            target.mode = idle_of(sel_src);
        end else begin
            target.mode = run_of(sel_src);
        end
        target.src = sel_src;
    end
endmodule

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic asleep,
    input  logic wake_evt,
    input  logic wdt_timeout,
    input  logic sw_busy,
    output logic wake_go,
    output logic wdt_reset
);
    logic pend_q;
    logic wake_in;
    logic wdt_rst_q;

    assign wake_in = wake_evt | wdt_timeout;
    assign wake_go = asleep & (wake_in | pend_q) & ~sw_busy;
    assign wdt_reset = wdt_rst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= 1'b0;
            wdt_rst_q <= 1'b0;
        end else begin
            wdt_rst_q <= wdt_timeout & ~asleep;
            if (!asleep || wake_go) begin
                pend_q <= 1'b0;
            end else if (wake_in) begin
                pend_q <= 1'b1;
            end
        end
    end

    // R9
    wdt_run_only_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_reset |-> $past(~asleep));

    // R10
    busy_blocks_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (asleep && wake_evt && sw_busy) |=> (pend_q || !asleep));
endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
    import pm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  pm_target_t        target,
    input  logic              wake_go,
    input  logic              pri_ready,
    input  logic              sw_busy,
    output mode_e             mode,
    output logic              sw_req,
    output logic [SRC_W-1:0]  sw_target
);
    mode_e mode_q;
    src_e  src_q;
    src_e  tgt_q;
    logic  req_q;
    logic  wait_q;

    assign mode      = mode_q;
    assign sw_req    = req_q;
    assign sw_target = tgt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= M_PRI_RUN;
            src_q  <= SRC_PRI;
            tgt_q  <= SRC_PRI;
            req_q  <= 1'b0;
            wait_q <= 1'b0;
        end else begin
            req_q <= 1'b0;
            if (cpu_runs(mode_q) && strobe) begin
                mode_q <= target.mode;
                wait_q <= 1'b0;
                if (target.src != src_q) begin
                    req_q <= 1'b1;
                    tgt_q <= target.src;
                    src_q <= target.src;
                end
            end else if (wake_go) begin
                mode_q <= run_of(src_q);
                wait_q <= (src_q != SRC_PRI);
            end else if (cpu_runs(mode_q) && wait_q && pri_ready && !sw_busy) begin
                mode_q <= M_PRI_RUN;
                src_q  <= SRC_PRI;
                tgt_q  <= SRC_PRI;
                req_q  <= 1'b1;
                wait_q <= 1'b0;
            end
        end
    end

    // R6
    stopped_cpu_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_runs(mode_q) && !wake_go) |=> $stable(mode_q));

    // R8
    pri_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (wait_q && !pri_ready && !strobe) |=> (mode_q == $past(mode_q)));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep_strobe,
    input  logic              idle_en,
    input  logic [SRC_W-1:0]  src_sel,
    input  logic              wake_evt,
    input  logic              wdt_timeout,
    input  logic              pri_ready,
    input  logic              sw_busy,
    output logic [MODE_W-1:0] mode,
    output logic              cpu_clk_en,
    output logic              periph_clk_en,
    output logic              sw_req,
    output logic [SRC_W-1:0]  sw_target,
    output logic              wdt_reset
);
    pm_target_t target;
    mode_e      mode_cur;
    logic       wake_go;
    logic       asleep;

    assign asleep        = ~cpu_runs(mode_cur);
    assign mode          = mode_cur;
    assign cpu_clk_en    = cpu_runs(mode_cur);
    assign periph_clk_en = (mode_cur != M_SLEEP);

    pm_mode_decode i_decode (
        .idle_en (idle_en),
        .src_sel (src_sel),
        .target  (target)
    );

    pm_wake_ctrl i_wake (
        .clk         (clk),
        .rst         (rst),
        .asleep      (asleep),
        .wake_evt    (wake_evt),
        .wdt_timeout (wdt_timeout),
        .sw_busy     (sw_busy),
        .wake_go     (wake_go),
        .wdt_reset   (wdt_reset)
    );

    pm_mode_fsm i_fsm (
        .clk       (clk),
        .rst       (rst),
        .strobe    (sleep_strobe),
        .target    (target),
        .wake_go   (wake_go),
        .pri_ready (pri_ready),
        .sw_busy   (sw_busy),
        .mode      (mode_cur),
        .sw_req    (sw_req),
        .sw_target (sw_target)
    );

    // R3
    sleep_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (sleep_strobe && !mode[MODE_W-1] && !idle_en && src_sel == 2'b00)
        |=> (mode == 3'b111 && !cpu_clk_en && !periph_clk_en));

    // R9
    wdt_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        (wdt_timeout && !mode[MODE_W-1] && !sleep_strobe)
        |=> (wdt_reset && $stable(mode)));

    // R10
    wake_held_chk: assert property (@(posedge clk) disable iff (rst)
        (mode[MODE_W-1] && sw_busy) |=> mode[MODE_W-1]);

    // R4
    req_target_chk: assert property (@(posedge clk) disable iff (rst)
        sw_req |-> ((mode == 3'b111) ? (sw_target == 2'b00)
                                     : (mode[SRC_W-1:0] == sw_target)));
endmodule

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sleep_strobe = 1'b0;
    logic       idle_en = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic       wake_evt = 1'b0;
    logic       wdt_timeout = 1'b0;
    logic       pri_ready = 1'b0;
    logic       sw_busy = 1'b0;
    logic [2:0] mode;
    logic       cpu_clk_en;
    logic       periph_clk_en;
    logic       sw_req;
    logic [1:0] sw_target;
    logic       wdt_reset;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pwr_mode_ctrl i_pwr_mode_ctrl (
        .clk(clk), .rst(rst), .sleep_strobe(sleep_strobe), .idle_en(idle_en),
        .src_sel(src_sel), .wake_evt(wake_evt), .wdt_timeout(wdt_timeout),
        .pri_ready(pri_ready), .sw_busy(sw_busy), .mode(mode),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .sw_req(sw_req), .sw_target(sw_target), .wdt_reset(wdt_reset)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic strobe(input logic ie, input logic [1:0] sel);
        idle_en = ie; src_sel = sel; sleep_strobe = 1'b1;
        tick();
        sleep_strobe = 1'b0;
    endtask

    task automatic wake();
        wake_evt = 1'b1;
        tick();
        wake_evt = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 mode", mode, 0);
        chk("R1 cpu_clk_en", cpu_clk_en, 1);
        chk("R1 periph_clk_en", periph_clk_en, 1);
        chk("R1 sw_req", sw_req, 0);
        chk("R1 wdt_reset", wdt_reset, 0);
    endtask

    task automatic t_run_switch();
        strobe(1'b0, 2'b01);
        chk("R2 SEC_RUN", mode, 3'b001);
        chk("R4 req", sw_req, 1);
        chk("R4 target", sw_target, 2'b01);
        tick();
        chk("R4 one-cycle", sw_req, 0);
        strobe(1'b0, 2'b01);
        chk("R4 same source no req", sw_req, 0);
        strobe(1'b0, 2'b11);
        chk("R6 resample RC_RUN", mode, 3'b010);
        chk("R4 target RC", sw_target, 2'b10);
        chk("R5 cpu in run", cpu_clk_en, 1);
    endtask

    task automatic t_idle_wake();
        strobe(1'b1, 2'b10);
        chk("R2 RC_IDLE", mode, 3'b110);
        chk("R4 no req same src", sw_req, 0);
        chk("R5 cpu gated", cpu_clk_en, 0);
        chk("R5 periph on", periph_clk_en, 1);
        strobe(1'b0, 2'b01);
        chk("R6 strobe ignored in idle", mode, 3'b110);
        idle_en = 1'b1; src_sel = 2'b01;
        wake();
        chk("R7 R12 wake RC_RUN", mode, 3'b010);
        tick(); tick();
        chk("R8 waits for primary", mode, 3'b010);
        pri_ready = 1'b1;
        tick();
        chk("R8 auto PRI_RUN", mode, 3'b000);
        chk("R8 req", sw_req, 1);
        chk("R8 target", sw_target, 2'b00);
        pri_ready = 1'b0;
        tick();
    endtask

    task automatic t_sleep();
        strobe(1'b0, 2'b00);
        chk("R3 SLEEP", mode, 3'b111);
        chk("R3 cpu off", cpu_clk_en, 0);
        chk("R3 periph off", periph_clk_en, 0);
        chk("R4 no req", sw_req, 0);
        wake();
        chk("R7 sleep wake", mode, 3'b000);
        strobe(1'b0, 2'b01);
        strobe(1'b0, 2'b00);
        chk("R3 SLEEP from SEC", mode, 3'b111);
        chk("R4 req to primary", sw_req, 1);
        chk("R4 target primary", sw_target, 2'b00);
        wake();
        pri_ready = 1'b1;
        tick();
        chk("R8 no switch from primary", sw_req, 0);
        chk("R7 stays PRI_RUN", mode, 3'b000);
        pri_ready = 1'b0;
    endtask

    task automatic t_wdt();
        wdt_timeout = 1'b1;
        tick();
        wdt_timeout = 1'b0;
        chk("R9 reset pulse", wdt_reset, 1);
        chk("R9 mode kept", mode, 3'b000);
        tick();
        chk("R9 pulse ends", wdt_reset, 0);
        strobe(1'b1, 2'b01);
        chk("R2 SEC_IDLE", mode, 3'b101);
        wdt_timeout = 1'b1;
        tick();
        wdt_timeout = 1'b0;
        chk("R9 idle wake", mode, 3'b001);
        chk("R9 no reset in idle", wdt_reset, 0);
        pri_ready = 1'b1;
        tick();
        chk("R8 back to PRI", mode, 3'b000);
        pri_ready = 1'b0;
    endtask

    task automatic t_busy();
        strobe(1'b1, 2'b01);
        sw_busy = 1'b1;
        wake();
        chk("R10 held", mode, 3'b101);
        tick(); tick();
        chk("R10 still held", mode, 3'b101);
        sw_busy = 1'b0;
        tick();
        chk("R10 released", mode, 3'b001);
        pri_ready = 1'b1;
        tick();
        chk("R8 PRI after busy", mode, 3'b000);
        pri_ready = 1'b0;
    endtask

    task automatic t_run_wake();
        wake();
        chk("R11 run wake no effect", mode, 3'b000);
        strobe(1'b1, 2'b00);
        chk("R2 PRI_IDLE", mode, 3'b100);
        tick(); tick();
        chk("R11 not remembered", mode, 3'b100);
        wake();
        chk("R7 PRI_RUN", mode, 3'b000);
        chk("R7 no req", sw_req, 0);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_run_switch();
        t_idle_wake();
        t_sleep();
        t_wdt();
        t_busy();
        t_run_wake();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule